// File: doc/BRIEF.md
# Per-Line Edge Capture Interrupt Unit

This block watches the low 24 lines of a digital I/O bank for edges. It takes already synchronized pin levels, a per-line edge-direction vector and a per-line arm vector. When an armed line shows an edge in its chosen direction, the matching bit of a 24-bit sticky event register is set. The bit stays set until host software clears it.

The host reads the event register as three bytes. It clears events with byte-wide writes, where a 0 in a data bit clears that event and a 1 leaves it alone. The block produces a three-bit summary with one bit per event byte, and a level interrupt request that stays high while any event is latched.

Edges are judged on the true pin level. Each cycle's sample is compared with the sample of the cycle before. The first sample after reset only sets the baseline.

Top module: `edge_irq_capture`

## Requirements
- R1: While reset is asserted and right after it, `evt_id`, `evt_pend` and `irq` are all 0.
- R2: When `edge_dir` bit i is 1, a low-to-high change of `pin_lvl` bit i is captured. When `edge_dir` bit i is 0, a high-to-low change is captured. The `evt_id` bit i becomes 1 after the same clock edge at which the new level is first sampled.
- R3: A line whose `arm` bit is 0 never sets its `evt_id` bit. With `arm` all zero, no event bit can become 1.
- R4: A set `evt_id` bit stays 1 until a host clear write removes it.
- R5: The clear write is a pulse on `clr_we` with `clr_sel` and `clr_data`. `clr_sel` 0 selects lines 7:0, 1 selects lines 15:8 and 2 selects lines 23:16. Data bit j maps to line 8*sel+j. A 0 clears that bit and a 1 keeps it. `clr_sel` = 3 changes nothing.
- R6: An edge on a line in the same cycle as a clear of that line wins, and the bit stays 1.
- R7: `evt_pend` bit k is 1 exactly when any of `evt_id` bits 8k+7 down to 8k is 1.
- R8: `irq` is 1 exactly when any `evt_id` bit is 1.
- R9: Changing `edge_dir` or `arm` while the pin is steady creates no event. The previous sample follows the pin even while the line is disarmed, so an edge that happened while disarmed is not captured later.
- R10: The first clock edge after reset release captures nothing, whatever the pin levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 24 | Synchronized true pin levels of lines 23:0 |
| edge_dir | input | 24 | Per-line direction: 1 selects rising, 0 selects falling |
| arm | input | 24 | Per-line capture enable |
| clr_we | input | 1 | Host clear-write strobe for one event byte |
| clr_sel | input | 2 | Event byte selected by the clear write |
| clr_data | input | 8 | Clear-write data: 0 clears, 1 keeps |
| evt_id | output | 24 | Latched event bits |
| evt_pend | output | 3 | Per-byte OR summary of `evt_id` |
| irq | output | 1 | Level interrupt request |

## Verification
Some properties are checked on every cycle:
- `irq` agrees with the pending summary.
- Latched bits hold when there is neither an event nor a write.
- Every detected event appears in the register one cycle later, even under a clear.
- No bit rises on a disarmed line.

Other behaviours need the bench's scenarios and its own model:
- the direction selection against real pin transitions;
- the baseline sample after reset;
- the ignored fourth byte select;
- the fact that an edge hidden while disarmed is not captured later.

// File: rtl/eic_pkg.sv
package eic_pkg;

  // Edge test for one line on true levels.
  function automatic logic line_edge(input logic cur, input logic prev,
                                     input logic rise_sel);
    logic hit;
    if (rise_sel) hit = cur & ~prev;
    else          hit = ~cur & prev;
    return hit;
  endfunction

  // Next value of one event bit: write-zero-clears, edge wins over clear.
  function automatic logic evt_next(input logic old_bit, input logic hit_bit,
                                    input logic wr_here, input logic keep_bit);
    logic nb;
    nb = old_bit;
    if (wr_here) nb = old_bit & keep_bit;
    return nb | hit_bit;
  endfunction

endpackage

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int LINES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_lvl,
  input  logic [LINES-1:0] edge_dir,
  input  logic [LINES-1:0] arm,
  output logic [LINES-1:0] edge_ev
);
  import eic_pkg::*;

  logic [LINES-1:0] prev_q;
  logic             primed_q;
  logic [LINES-1:0] raw_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_lvl;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign raw_hit[i] = line_edge(pin_lvl[i], prev_q[i], edge_dir[i]);
  end

  assign edge_ev = primed_q ? (raw_hit & arm) : '0;

endmodule

// File: rtl/eic_id_bank.sv
module eic_id_bank #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int LINES    = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  edge_ev,
  input  logic              clr_we,
  input  logic [SEL_W-1:0]  clr_sel,
  input  logic [BYTE_W-1:0] clr_data,
  output logic [LINES-1:0]  id_q
);
  import eic_pkg::*;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    logic wr_here;
    assign wr_here = clr_we && (clr_sel == SEL_W'(k));
    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) id_q[k*BYTE_W+j] <= 1'b0;
        else id_q[k*BYTE_W+j] <= evt_next(id_q[k*BYTE_W+j], edge_ev[k*BYTE_W+j],
                                          wr_here, clr_data[j]);
      end
    end
  end

endmodule

// File: rtl/eic_pend_summary.sv
module eic_pend_summary #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int LINES    = BYTE_W * NUM_BYTES
) (
  input  logic [LINES-1:0]     id_q,
  output logic [NUM_BYTES-1:0] pend
);
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_sum
    assign pend[k] = |id_q[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int LINES    = BYTE_W * NUM_BYTES,
  localparam int SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES-1:0]     pin_lvl,
  input  logic [LINES-1:0]     edge_dir,
  input  logic [LINES-1:0]     arm,
  input  logic                 clr_we,
  input  logic [SEL_W-1:0]     clr_sel,
  input  logic [BYTE_W-1:0]    clr_data,
  output logic [LINES-1:0]     evt_id,
  output logic [NUM_BYTES-1:0] evt_pend,
  output logic                 irq
);
  logic [LINES-1:0] edge_ev;

  eic_edge_detect #(.LINES(LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .edge_dir(edge_dir),
    .arm(arm), .edge_ev(edge_ev)
  );

  eic_id_bank #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .edge_ev(edge_ev), .clr_we(clr_we),
    .clr_sel(clr_sel), .clr_data(clr_data), .id_q(evt_id)
  );

  eic_pend_summary #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_sum (
    .id_q(evt_id), .pend(evt_pend)
  );

  assign irq = (evt_id != '0);

endmodule

// File: rtl/edge_irq_capture_chk.sv
module edge_irq_capture_chk #(
  parameter int LINES = 24,
  parameter int NB    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] arm,
  input logic             clr_we,
  input logic [LINES-1:0] edge_ev,
  input logic [LINES-1:0] evt_id,
  input logic [NB-1:0]    evt_pend,
  input logic             irq
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_IRQ_MATCHES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (evt_pend != '0)); // R8

  AST_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !clr_we && edge_ev == '0) |=> $stable(evt_id)); // R4

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && edge_ev != '0) |=> ((evt_id & $past(edge_ev)) == $past(edge_ev))); // R6

  AST_DISARMED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> ((evt_id & ~$past(evt_id) & ~$past(arm)) == '0)); // R3

  AST_NO_EVENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (edge_ev == '0)); // R10
endmodule

bind edge_irq_capture edge_irq_capture_chk #(.LINES(LINES), .NB(NUM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .clr_we(clr_we), .edge_ev(edge_ev),
  .evt_id(evt_id), .evt_pend(evt_pend), .irq(irq)
);

// File: tb/edge_irq_capture_test.sv
module edge_irq_capture_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pin_lvl, edge_dir, arm;
  logic        clr_we;
  logic [1:0]  clr_sel;
  logic [7:0]  clr_data;
  logic [23:0] evt_id;
  logic [2:0]  evt_pend;
  logic        irq;

  int n_chk = 0, n_err = 0;
  logic [23:0] m_prev, m_id;
  logic        m_primed;

  always #5 clk = ~clk;

  edge_irq_capture uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .edge_dir(edge_dir), .arm(arm),
    .clr_we(clr_we), .clr_sel(clr_sel), .clr_data(clr_data),
    .evt_id(evt_id), .evt_pend(evt_pend), .irq(irq)
  );

  function automatic logic [2:0] exp_pend(input logic [23:0] v);
    logic [2:0] p = '0;
    for (int b = 0; b < 24; b++) if (v[b]) p[b/8] = 1'b1;
    return p;
  endfunction

  function automatic logic [23:0] exp_next(input logic [23:0] id, input logic [23:0] cur,
      input logic [23:0] prv, input logic [23:0] dir, input logic [23:0] en,
      input logic primed, input logic we, input logic [1:0] sel, input logic [7:0] d);
    logic [23:0] r = id;
    for (int b = 0; b < 24; b++) begin
      if (we && sel != 2'd3 && (b / 8) == int'(sel) && !d[b % 8]) r[b] = 1'b0;
      if (primed && en[b] && cur[b] != prv[b] && cur[b] == dir[b]) r[b] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    m_id = exp_next(m_id, pin_lvl, m_prev, edge_dir, arm, m_primed,
                    clr_we, clr_sel, clr_data);
    m_prev = pin_lvl;
    m_primed = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_we = 1'b0;
    chk({tag, " id"}, evt_id, m_id);
    chk("R7 pend", {21'd0, evt_pend}, {21'd0, exp_pend(m_id)});
    chk("R8 irq", {23'd0, irq}, {23'd0, (m_id != 0)});
  endtask

  task automatic clear(input logic [1:0] s, input logic [7:0] d, input string tag);
    clr_we = 1'b1; clr_sel = s; clr_data = d;
    step(tag);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; pin_lvl = 24'h0000FF; edge_dir = '1; arm = '1;
    clr_we = 1'b0; clr_sel = '0; clr_data = '0;
    m_prev = '0; m_id = '0; m_primed = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 id", evt_id, 24'h0);
    chk("R1 pend", {21'd0, evt_pend}, 24'h0);
    chk("R1 irq", {23'd0, irq}, 24'h0);
    rst_n = 1'b1;
    step("R10 baseline");
    chk("R10 no event", evt_id, 24'h0);
    pin_lvl[8] = 1'b1; step("R2 rise");
    chk("R2 rise bit8", evt_id, 24'h000100);
    edge_dir[0] = 1'b0; step("R9 dir change");
    chk("R9 no event", evt_id, 24'h000100);
    pin_lvl[0] = 1'b0; step("R2 fall");
    chk("R2 fall bit0", evt_id, 24'h000101);
    chk("R7 pend", {21'd0, evt_pend}, 24'h000003);
    pin_lvl[9] = 1'b1; edge_dir[9] = 1'b0; step("R2 wrong dir");
    chk("R2 wrong dir", evt_id, 24'h000101);
    repeat (3) step("R4 hold");
    chk("R4 sticky", evt_id, 24'h000101);
    clear(2'd3, 8'h00, "R5 sel3");
    chk("R5 sel3 ignored", evt_id, 24'h000101);
    clear(2'd1, 8'h00, "R5 clr byte1");
    chk("R5 byte1 cleared", evt_id, 24'h000001);
    clear(2'd0, 8'hFE, "R5 clr bit0");
    chk("R5 bit0 cleared", evt_id, 24'h0);
    chk("R8 irq low", {23'd0, irq}, 24'h0);
    arm = '0; pin_lvl = ~pin_lvl; edge_dir = pin_lvl; step("R3 disarmed");
    chk("R3 no capture", evt_id, 24'h0);
    arm = '1; step("R9 rearm steady");
    chk("R9 hidden edge", evt_id, 24'h0);
    edge_dir[17] = ~pin_lvl[17]; pin_lvl[17] = ~pin_lvl[17]; step("R2 bit17");
    edge_dir[16] = ~pin_lvl[16]; pin_lvl[16] = ~pin_lvl[16];
    clear(2'd2, 8'h00, "R6 edge vs clear");
    chk("R6 edge wins", evt_id, 24'h010000);
    chk("R7 pend byte2", {21'd0, evt_pend}, 24'h000004);
    for (int c = 0; c < 400; c++) begin
      pin_lvl = pin_lvl ^ ($urandom() & $urandom() & 24'hFFFFFF);
      if (($urandom() % 8) == 0) edge_dir = 24'($urandom());
      if (($urandom() % 8) == 0) arm = 24'($urandom());
      if (($urandom() % 4) == 0) begin
        clr_we = 1'b1; clr_sel = 2'($urandom()); clr_data = 8'($urandom());
      end
      step("R2 R3 R5 random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule